// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a one-bit signal by a chosen number of clock cycles. The signal passes through a chain of shift-register stages whose lengths are powers of two, from 512 cycles down to 1 cycle. A 2:1 multiplexer either includes each stage in the path or bypasses it. Every stage shifts on every clock, whether or not it is in the path. A registered output stage adds one fixed cycle of latency. It also forces the output low while the disable input is high.

A 10-bit delay code and a cascade-control bit reach the chain through a load/hold latch. While load-enable is low, the latch is transparent and the delay follows the code pins. While load-enable is high, the latch holds the values taken at the last clock edge on which load-enable was low. Two override inputs force the delay to the shortest or the longest setting. The longest setting is one cycle beyond the all-ones code, provided by an extra one-cycle stage that only the maximum override switches in. A complementary pair of cascade outputs shows the latched cascade bit, so that several lines can be chained for a longer range.

Top module: `bw_delay_line`

## Requirements
- R1: With no override and the output enabled, `dout` after clock edge n equals `din` sampled at edge n−D, where D = sum over k of sel_code[k]·2^k (bit 0 is worth 1 cycle, bit 9 is worth 512). This holds once D+1 cycles have passed since the last change of D.
- R2: While `load_en` is low, the code and `casc_ctl` are transparent: the delay and the cascade outputs follow the pins, and the cascade outputs update one clock after the pins.
- R3: While `load_en` is high, changes on `sel_code` and `casc_ctl` have no effect. The held values are those sampled at the last edge on which `load_en` was low.
- R4: With `force_min` high, D = 0 whatever the code.
- R5: With `force_max` high and `force_min` low, D = 1024, one more than the all-ones code gives.
- R6: When both overrides are high, `force_min` wins (D = 0). The overrides act on the delay only and do not change the cascade outputs.
- R7: If `out_dis` is high at an edge, `dout` is 0 after that edge. If it is low, the delayed value appears.
- R8: `casc_out` equals the latched cascade bit and `casc_out_n` is its complement: 0/1 for a latched 0, and 1/0 for a latched 1.
- R9: A synchronous reset clears the stages, the held code and the held cascade bit. After reset, `dout`=0, `casc_out`=0, `casc_out_n`=1, and with `load_en` high the delay is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to be delayed |
| sel_code | input | 10 | Delay code, binary weighted |
| casc_ctl | input | 1 | Cascade-control bit, latched with the code |
| load_en | input | 1 | Low: transparent; high: hold |
| force_min | input | 1 | Force zero programmable delay (highest priority) |
| force_max | input | 1 | Force maximum delay (1024) |
| out_dis | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed, gated output (registered) |
| casc_out | output | 1 | True cascade output |
| casc_out_n | output | 1 | Complement cascade output |

## Verification
The assertions check, on every cycle, the following: output gating under `out_dis`, complementarity of the cascade pair, cascade transparency while `load_en` is low, stability of the effective code while `load_en` stays high, and single-cycle pass-through under the minimum override. Only the bench's scenarios can show the exact delay for each code and the 1024-cycle maximum, because those compare `dout` against the input history after the chain has refilled. The same applies to priority between the overrides and to the state left behind by reset.

// File: rtl/bwdl_pkg.sv
package bwdl_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_MIN  = 2'd1,
    OVR_MAX  = 2'd2
  } ovr_mode_e;

  // Length of the chain stage at position pos, counted from the input end.
  function automatic int unsigned stage_len(input int unsigned pos, input int unsigned code_w);
    return 32'd1 << (code_w - 1 - pos);
  endfunction

  // Override priority: minimum beats maximum, both beat the code.
  function automatic ovr_mode_e pick_override(input logic fmin, input logic fmax);
    if (fmin)      return OVR_MIN;
    else if (fmax) return OVR_MAX;
    else           return OVR_NONE;
  endfunction

endpackage

// File: rtl/bwdl_code_latch.sv
module bwdl_code_latch #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              casc_in,
  output logic [CODE_W-1:0] code_eff,
  output logic              casc_eff
);

  logic [CODE_W-1:0] code_held;
  logic              casc_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_held <= '0;
      casc_held <= 1'b0;
    end else if (!load_en) begin
      code_held <= code_in;
      casc_held <= casc_in;
    end
  end

  always_comb begin
    if (load_en) begin
      code_eff = code_held;
      casc_eff = casc_held;
    end else begin
      code_eff = code_in;
      casc_eff = casc_in;
    end
  end

endmodule

// File: rtl/bwdl_sel_decode.sv
module bwdl_sel_decode #(
  parameter int CODE_W = 10
) (
  input  logic              force_min,
  input  logic              force_max,
  input  logic [CODE_W-1:0] code_eff,
  output logic [CODE_W-1:0] stage_sel,
  output logic              extra_sel
);
  import bwdl_pkg::*;

  ovr_mode_e mode;

  always_comb begin
    mode = pick_override(force_min, force_max);
    unique case (mode)
      OVR_MIN: begin
        stage_sel = '0;
        extra_sel = 1'b0;
      end
      OVR_MAX: begin
        stage_sel = '1;
        extra_sel = 1'b1;
      end
      default: begin
        stage_sel = code_eff;
        extra_sel = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bwdl_stage.sv
module bwdl_stage #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sin,
  input  logic use_stage,
  output logic sout
);

  logic [LEN-1:0] sr;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= sin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LEN-2:0], sin};
      end
    end
  endgenerate

  assign sout = use_stage ? sr[LEN-1] : sin;

endmodule

// File: rtl/bw_delay_line.sv
module bw_delay_line #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              casc_ctl,
  input  logic              load_en,
  input  logic              force_min,
  input  logic              force_max,
  input  logic              out_dis,
  output logic              dout,
  output logic              casc_out,
  output logic              casc_out_n
);
  import bwdl_pkg::*;

  localparam int NSTG = CODE_W + 1;

  logic [CODE_W-1:0] code_eff;
  logic              casc_eff;
  logic [CODE_W-1:0] stage_sel;
  logic              extra_sel;
  logic [NSTG:0]     chain;

  bwdl_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .code_in  (sel_code),
    .casc_in  (casc_ctl),
    .code_eff (code_eff),
    .casc_eff (casc_eff)
  );

  bwdl_sel_decode #(.CODE_W(CODE_W)) u_dec (
    .force_min (force_min),
    .force_max (force_max),
    .code_eff  (code_eff),
    .stage_sel (stage_sel),
    .extra_sel (extra_sel)
  );

  assign chain[0] = din;

  // Heaviest stage nearest the input, lightest last.
  generate
    for (genvar p = 0; p < CODE_W; p++) begin : g_stg
      localparam int LEN = int'(stage_len(p, CODE_W));
      bwdl_stage #(.LEN(LEN)) u_stg (
        .clk       (clk),
        .rst       (rst),
        .sin       (chain[p]),
        .use_stage (stage_sel[CODE_W-1-p]),
        .sout      (chain[p+1])
      );
    end
  endgenerate

  // One extra unit reachable only through the maximum override.
  bwdl_stage #(.LEN(1)) u_extra (
    .clk       (clk),
    .rst       (rst),
    .sin       (chain[CODE_W]),
    .use_stage (extra_sel),
    .sout      (chain[NSTG])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      casc_out   <= 1'b0;
      casc_out_n <= 1'b1;
    end else begin
      dout       <= out_dis ? 1'b0 : chain[NSTG];
      casc_out   <= casc_eff;
      casc_out_n <= ~casc_eff;
    end
  end

endmodule

// File: rtl/bw_delay_line_chk.sv
module bw_delay_line_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              din,
  input logic              casc_ctl,
  input logic              load_en,
  input logic              force_min,
  input logic              out_dis,
  input logic              dout,
  input logic              casc_out,
  input logic              casc_out_n,
  input logic [CODE_W-1:0] code_eff
);

  // R7
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_dis |=> !dout);

  // R8
  casc_pair_chk: assert property (@(posedge clk) disable iff (rst)
    casc_out_n == !casc_out);

  // R2
  casc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> casc_out == $past(casc_ctl));

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && load_en && $past(load_en)) |-> $stable(code_eff));

  // R4
  min_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (force_min && !out_dis) |=> dout == $past(din));

endmodule

bind bw_delay_line bw_delay_line_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .din        (din),
  .casc_ctl   (casc_ctl),
  .load_en    (load_en),
  .force_min  (force_min),
  .out_dis    (out_dis),
  .dout       (dout),
  .casc_out   (casc_out),
  .casc_out_n (casc_out_n),
  .code_eff   (code_eff)
);

// File: tb/bw_delay_line_tb.sv
module bw_delay_line_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [9:0] sel_code = '0;
  logic       casc_ctl = 1'b0;
  logic       load_en = 1'b0;
  logic       force_min = 1'b0;
  logic       force_max = 1'b0;
  logic       out_dis = 1'b0;
  logic       dout, casc_out, casc_out_n;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic hist [0:2047];
  int cnt = 0;

  always #4 clk = ~clk;

  bw_delay_line u_dut (
    .clk(clk), .rst(rst), .din(din), .sel_code(sel_code), .casc_ctl(casc_ctl),
    .load_en(load_en), .force_min(force_min), .force_max(force_max),
    .out_dis(out_dis), .dout(dout), .casc_out(casc_out), .casc_out_n(casc_out_n)
  );

  always @(posedge clk) begin
    hist[cnt & 2047] = din;
    cnt = cnt + 1;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    din = lfsr[0];
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Let the chain refill, then compare dout with the input history.
  task automatic check_delay(input string req, input int d, input logic gated);
    int bad = 0;
    int first_act = -1;
    int first_exp = -1;
    repeat (1100) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      logic e;
      @(negedge clk);
      e = gated ? 1'b0 : hist[(cnt - 1 - d) & 2047];
      if (dout !== e) begin
        if (bad == 0) begin first_act = int'(dout); first_exp = int'(e); end
        bad++;
      end
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: delay %0d, %0d mismatches, actual %0d expected %0d",
               req, d, bad, first_act, first_exp);
    end
  endtask

  task automatic t_reset;
    check_bit("R9 dout", dout, 1'b0);
    check_bit("R9 casc_out", casc_out, 1'b0);
    check_bit("R9 casc_out_n", casc_out_n, 1'b1);
  endtask

  task automatic t_codes;
    int codes [5] = '{0, 1, 5, 300, 1023};
    load_en = 1'b0;
    foreach (codes[i]) begin
      sel_code = codes[i][9:0];
      check_delay("R1 code weighting", codes[i], 1'b0);
    end
  endtask

  task automatic t_hold;
    load_en = 1'b0; sel_code = 10'd7; casc_ctl = 1'b0;
    repeat (2) @(negedge clk);
    load_en = 1'b1;
    @(negedge clk);
    sel_code = 10'd100; casc_ctl = 1'b1;
    check_delay("R3 held code ignores pins", 7, 1'b0);
    check_bit("R3 held cascade", casc_out, 1'b0);
    load_en = 1'b0;
    repeat (2) @(negedge clk);
    check_bit("R2 cascade transparent", casc_out, 1'b1);
    check_bit("R8 complement", casc_out_n, 1'b0);
    check_delay("R2 transparent code", 100, 1'b0);
  endtask

  task automatic t_overrides;
    sel_code = 10'd300; load_en = 1'b0;
    force_min = 1'b1;
    check_delay("R4 force_min", 0, 1'b0);
    force_min = 1'b0; force_max = 1'b1;
    check_delay("R5 force_max", 1024, 1'b0);
    casc_ctl = 1'b0;
    force_min = 1'b1;
    check_delay("R6 min over max", 0, 1'b0);
    check_bit("R6 cascade unaffected", casc_out, 1'b0);
    force_min = 1'b0; force_max = 1'b0;
  endtask

  task automatic t_gate;
    sel_code = 10'd3;
    out_dis = 1'b1;
    check_delay("R7 output disabled", 3, 1'b1);
    out_dis = 1'b0;
    check_delay("R7 output enabled", 3, 1'b0);
  endtask

  task automatic t_reset_hold;
    load_en = 1'b0; sel_code = 10'd5; casc_ctl = 1'b1;
    repeat (2) @(negedge clk);
    load_en = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R9 cascade cleared", casc_out, 1'b0);
    check_delay("R9 held code cleared", 0, 1'b0);
    load_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_codes;
    t_hold;
    t_overrides;
    t_gate;
    t_reset_hold;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule